// File: doc/BRIEF.md
# Opcode Latch and Cycle Sequencer

This block is the control core of a small processor whose instructions each take a varying number of clock cycles. An 8-bit data bus delivers every opcode. The block captures the opcode into an instruction register at the end of a fetch cycle. It runs a per-instruction step counter that is zero during the fetch and rises by one each clock until the instruction's final cycle. A combinational decoder maps the pair (latched opcode, step) to a vector of register-transfer strobes for the datapath. Some of those strobes mark 16-bit internal transfers, even though the external bus is 8 bits wide.

During an instruction's final cycle, the decoder raises a fetch request, so the next cycle becomes a fetch. An interrupt request seen in that final cycle is held as pending. At the next fetch the bus byte is then ignored, and a forced interrupt opcode is loaded in its place. That opcode runs its own stacking and vector-load sequence. Opcodes that have no table entry run as a two-cycle idle instruction.

Top module: `opseq_core`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves the block in a fetch cycle with `step_o` = 0, `ctl_o` = 0x03 and `irq_ack_o` = 0. The reset also cancels a pending interrupt and stops any instruction in progress.
- R2: `ir_o` takes the value of `bus_din` only at the clock edge that ends a fetch cycle. The value then appears from the next cycle on. Values on `bus_din` in any other cycle leave `ir_o` unchanged.
- R3: `step_o` is 0 in every fetch cycle. It then rises by exactly one per clock, and returns to 0 on the edge after an instruction's final cycle.
- R4: An instruction's length, counting its fetch cycle, depends on the opcode:
  - 0xA9 (load immediate) takes 2 cycles.
  - 0x6D (16-bit add) takes 4 cycles.
  - 0x8D (16-bit store) takes 5 cycles.
  - 0x00 (interrupt entry) takes 6 cycles.
- R5: The `ctl_o` bits are: bit0 opcode read, bit1 program-counter increment, bit2 memory read, bit3 memory write, bit4 accumulator load, bit5 ALU start, bit6 16-bit transfer, bit7 vector load. A normal fetch cycle gives 0x03. The later steps give:
  - 0xA9: step1 = 0x16.
  - 0x6D: steps 1 to 3 = 0x06, 0x06, 0x70.
  - 0x8D: steps 1 to 4 = 0x06, 0x06, 0x08, 0x48.
  - 0x00: steps 1 to 5 = 0x00, 0x08, 0x08, 0x08, 0xC0.
- R6: `fetch_req_o` is high in the final cycle of each instruction and low in every other cycle.
- R7: If `irq_req` is high in an instruction's final cycle, the next fetch cycle shows `irq_ack_o` = 1 and `ctl_o` = 0x00, and `ir_o` becomes 0x00 regardless of `bus_din`. If `irq_req` is high only in cycles that are not final, it has no effect.
- R8: Any opcode not listed in R4 runs as a 2-cycle instruction, with `ctl_o` = 0x00 in step 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_din | input | 8 | Data bus carrying the opcode in fetch cycles |
| irq_req | input | 1 | Interrupt request level |
| ctl_o | output | 8 | Register-transfer strobes for the current cycle |
| ir_o | output | 8 | Latched instruction register |
| step_o | output | 3 | Step index within the current instruction |
| fetch_req_o | output | 1 | Final cycle of the instruction; the next cycle is a fetch |
| irq_ack_o | output | 1 | The current fetch cycle is replaced by interrupt entry |

## Verification
Two events can fall in the same cycle: interrupt sampling and the fetch request that ends an instruction. The bench raises `irq_req` exactly in the final cycle of a store instruction. It then expects the following fetch to be acknowledged, to show all strobes low, and to load 0x00 even though a real opcode sits on the bus. As a contrast, the bench holds `irq_req` high through every non-final cycle of another instruction and expects a plain fetch. A third case asserts reset during a pending interrupt's fetch. The bench then requires that the acknowledge is gone and that an ordinary fetch follows.

// File: rtl/opseq_pkg.sv
package opseq_pkg;

   // Strobe vector, most significant field first
   typedef struct packed {
      logic vec_ld;
      logic wide;
      logic alu_go;
      logic acc_ld;
      logic mem_wr;
      logic mem_rd;
      logic pc_inc;
      logic op_rd;
   } ctl_t;

   localparam int CTL_W = $bits(ctl_t);

   // Opcodes with a table entry (8-bit encodings)
   localparam logic [7:0] OPC_LDI  = 8'hA9;
   localparam logic [7:0] OPC_ADDW = 8'h6D;
   localparam logic [7:0] OPC_STW  = 8'h8D;

   // Longest sequence in the table, fetch included
   localparam int LONGEST_SEQ = 6;

   // Named strobe patterns
   localparam ctl_t CTL_NONE    = ctl_t'(8'h00);
   localparam ctl_t CTL_FETCH   = ctl_t'(8'h03);
   localparam ctl_t CTL_OPERAND = ctl_t'(8'h06);
   localparam ctl_t CTL_LDIMM   = ctl_t'(8'h16);
   localparam ctl_t CTL_ADDW    = ctl_t'(8'h70);
   localparam ctl_t CTL_WR_LO   = ctl_t'(8'h08);
   localparam ctl_t CTL_WR_HI   = ctl_t'(8'h48);
   localparam ctl_t CTL_PUSH    = ctl_t'(8'h08);
   localparam ctl_t CTL_VECTOR  = ctl_t'(8'hC0);

endpackage

// File: rtl/opseq_step_ctr.sv
module opseq_step_ctr #(
   parameter int STEP_W = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              last_i,
   output logic [STEP_W-1:0] step_o,
   output logic              fetch_o
);

   localparam logic [STEP_W-1:0] STEP_ONE = STEP_W'(1);

   logic [STEP_W-1:0] step_q;

   always_ff @(posedge clk) begin
      if (rst || last_i) begin
         step_q <= '0;
      end else begin
         step_q <= step_q + STEP_ONE;
      end
   end

   assign step_o  = step_q;
   assign fetch_o = (step_q == '0);

   AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (rst) !last_i |=> (step_q != '0)) else $error("step returned to zero without a final cycle"); // R3
   AST_STEP_RESTARTS: assert property (@(posedge clk) disable iff (rst) last_i |=> (step_q == '0)) else $error("step did not restart after final cycle"); // R3

endmodule

// File: rtl/opseq_ireg.sv
module opseq_ireg #(
   parameter int               OPC_W   = 8,
   parameter bit               IRQ_EN  = 1'b1,
   parameter logic [OPC_W-1:0] IRQ_OPC = '0,
   parameter logic [OPC_W-1:0] RST_OPC = OPC_W'(8'hEA)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             fetch_i,
   input  logic             last_i,
   input  logic [OPC_W-1:0] bus_i,
   input  logic             irq_i,
   output logic [OPC_W-1:0] ir_o,
   output logic             take_irq_o
);

   logic [OPC_W-1:0] ir_q;
   logic             take_irq;

   generate
      if (IRQ_EN) begin : g_irq
         logic pend_q;

         always_ff @(posedge clk) begin
            if (rst) begin
               pend_q <= 1'b0;
            end else if (last_i && irq_i) begin
               pend_q <= 1'b1;
            end else if (fetch_i) begin
               pend_q <= 1'b0;
            end
         end

         assign take_irq = pend_q;

         AST_IRQ_AT_LAST: assert property (@(posedge clk) disable iff (rst) $rose(pend_q) |-> $past(last_i)) else $error("interrupt captured outside a final cycle"); // R7
         AST_IRQ_FORCED: assert property (@(posedge clk) disable iff (rst) (fetch_i && pend_q) |=> (ir_q == IRQ_OPC)) else $error("interrupt opcode not substituted"); // R7
      end else begin : g_noirq
         assign take_irq = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         ir_q <= RST_OPC;
      end else if (fetch_i) begin
         ir_q <= take_irq ? IRQ_OPC : bus_i;
      end
   end

   assign ir_o       = ir_q;
   assign take_irq_o = take_irq;

   AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst) !fetch_i |=> $stable(ir_q)) else $error("instruction register moved outside fetch"); // R2

endmodule

// File: rtl/opseq_decode.sv
module opseq_decode
   import opseq_pkg::*;
#(
   parameter int               OPC_W   = 8,
   parameter int               STEP_W  = 3,
   parameter logic [OPC_W-1:0] IRQ_OPC = '0
) (
   input  logic [OPC_W-1:0]  op_i,
   input  logic [STEP_W-1:0] step_i,
   input  logic              take_irq_i,
   output ctl_t              ctl_o,
   output logic              last_o,
   output logic              ack_o
);

   localparam logic [OPC_W-1:0] K_LDI  = OPC_W'(OPC_LDI);
   localparam logic [OPC_W-1:0] K_ADDW = OPC_W'(OPC_ADDW);
   localparam logic [OPC_W-1:0] K_STW  = OPC_W'(OPC_STW);

   always_comb begin
      ctl_o  = CTL_NONE;
      last_o = 1'b0;
      ack_o  = 1'b0;
      if (step_i == '0) begin
         // Fetch cycle: bus read unless an interrupt takes its place
         ack_o = take_irq_i;
         if (!take_irq_i) begin
            ctl_o = CTL_FETCH;
         end
      end else if (op_i == IRQ_OPC) begin
         case (int'(step_i))
            1:       ctl_o = CTL_NONE;
            2, 3, 4: ctl_o = CTL_PUSH;
            5: begin
               ctl_o  = CTL_VECTOR;
               last_o = 1'b1;
            end
            default: last_o = 1'b1;
         endcase
      end else if (op_i == K_LDI) begin
         ctl_o  = (int'(step_i) == 1) ? CTL_LDIMM : CTL_NONE;
         last_o = 1'b1;
      end else if (op_i == K_ADDW) begin
         case (int'(step_i))
            1, 2: ctl_o = CTL_OPERAND;
            3: begin
               ctl_o  = CTL_ADDW;
               last_o = 1'b1;
            end
            default: last_o = 1'b1;
         endcase
      end else if (op_i == K_STW) begin
         case (int'(step_i))
            1, 2: ctl_o = CTL_OPERAND;
            3:    ctl_o = CTL_WR_LO;
            4: begin
               ctl_o  = CTL_WR_HI;
               last_o = 1'b1;
            end
            default: last_o = 1'b1;
         endcase
      end else begin
         // Opcode without entry: one idle step after the fetch
         last_o = 1'b1;
      end
   end

endmodule

// File: rtl/opseq_core.sv
module opseq_core
   import opseq_pkg::*;
#(
   parameter int               OPC_W   = 8,
   parameter int               STEP_W  = 3,
   parameter bit               IRQ_EN  = 1'b1,
   parameter logic [OPC_W-1:0] IRQ_OPC = '0,
   parameter logic [OPC_W-1:0] RST_OPC = OPC_W'(8'hEA)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [OPC_W-1:0]  bus_din,
   input  logic              irq_req,
   output logic [CTL_W-1:0]  ctl_o,
   output logic [OPC_W-1:0]  ir_o,
   output logic [STEP_W-1:0] step_o,
   output logic              fetch_req_o,
   output logic              irq_ack_o
);

   localparam int MIN_STEP_W = $clog2(LONGEST_SEQ);

   initial begin
      assert (OPC_W >= 8) else $error("OPC_W must hold an 8-bit opcode");
      assert (STEP_W >= MIN_STEP_W) else $error("STEP_W too small for longest sequence");
      assert (IRQ_OPC != OPC_W'(OPC_LDI) && IRQ_OPC != OPC_W'(OPC_ADDW) && IRQ_OPC != OPC_W'(OPC_STW))
         else $error("IRQ_OPC collides with a table opcode");
   end

   logic              fetch;
   logic              last;
   logic              take_irq;
   logic              ack;
   logic [STEP_W-1:0] step;
   logic [OPC_W-1:0]  ir;
   ctl_t              ctl;

   opseq_step_ctr #(
      .STEP_W (STEP_W)
   ) u_ctr (
      .clk     (clk),
      .rst     (rst),
      .last_i  (last),
      .step_o  (step),
      .fetch_o (fetch)
   );

   opseq_ireg #(
      .OPC_W   (OPC_W),
      .IRQ_EN  (IRQ_EN),
      .IRQ_OPC (IRQ_OPC),
      .RST_OPC (RST_OPC)
   ) u_ireg (
      .clk        (clk),
      .rst        (rst),
      .fetch_i    (fetch),
      .last_i     (last),
      .bus_i      (bus_din),
      .irq_i      (irq_req),
      .ir_o       (ir),
      .take_irq_o (take_irq)
   );

   opseq_decode #(
      .OPC_W   (OPC_W),
      .STEP_W  (STEP_W),
      .IRQ_OPC (IRQ_OPC)
   ) u_dec (
      .op_i       (ir),
      .step_i     (step),
      .take_irq_i (take_irq),
      .ctl_o      (ctl),
      .last_o     (last),
      .ack_o      (ack)
   );

   assign ctl_o       = ctl;
   assign ir_o        = ir;
   assign step_o      = step;
   assign fetch_req_o = last;
   assign irq_ack_o   = ack;

   AST_FETCH_FOLLOWS_LAST: assert property (@(posedge clk) disable iff (rst) last |=> (step == '0)) else $error("no fetch after final cycle"); // R6
   AST_ACK_IN_FETCH: assert property (@(posedge clk) disable iff (rst) ack |-> (fetch && !ctl.pc_inc && !ctl.op_rd)) else $error("acknowledge outside a suppressed fetch"); // R7
   AST_BUS_ONE_WAY: assert property (@(posedge clk) disable iff (rst) !(ctl.mem_rd && ctl.mem_wr)) else $error("read and write strobes together"); // R5
   AST_FETCH_NOT_LAST: assert property (@(posedge clk) disable iff (rst) fetch |-> !last) else $error("fetch cycle flagged final"); // R4

endmodule

// File: tb/opseq_core_test.sv
`timescale 1ns/1ps
module opseq_core_test;

   typedef struct {
      int    step;
      int    ctl;
      int    freq;
      int    ack;
      bit    chk_ir;
      int    ir;
      string tag;
   } item_t;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] bus_din = 8'h00;
   logic       irq_req = 1'b0;
   logic [7:0] ctl_o;
   logic [7:0] ir_o;
   logic [2:0] step_o;
   logic       fetch_req_o;
   logic       irq_ack_o;

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    pend  = 1'b0;
   item_t q[$];

   always #2 clk = ~clk;

   opseq_core uut (
      .clk         (clk),
      .rst         (rst),
      .bus_din     (bus_din),
      .irq_req     (irq_req),
      .ctl_o       (ctl_o),
      .ir_o        (ir_o),
      .step_o      (step_o),
      .fetch_req_o (fetch_req_o),
      .irq_ack_o   (irq_ack_o)
   );

   // Expected sequence lengths and strobes (R4, R5, R8)
   function automatic int exp_len(input logic [7:0] op);
      case (op)
         8'hA9:   return 2;
         8'h6D:   return 4;
         8'h8D:   return 5;
         8'h00:   return 6;
         default: return 2;
      endcase
   endfunction

   function automatic bit known(input logic [7:0] op);
      return (op == 8'hA9) || (op == 8'h6D) || (op == 8'h8D) || (op == 8'h00);
   endfunction

   function automatic int exp_ctl(input logic [7:0] op, input int s);
      case (op)
         8'hA9: return 'h16;
         8'h6D: return (s == 3) ? 'h70 : 'h06;
         8'h8D: return (s <= 2) ? 'h06 : (s == 3) ? 'h08 : 'h48;
         8'h00: return (s == 1) ? 'h00 : (s == 5) ? 'hC0 : 'h08;
         default: return 'h00;
      endcase
   endfunction

   task automatic push_item(input int step, input int ctl, input int freq, input int ack,
                            input bit chk_ir, input int ir, input string tag);
      item_t it;
      it.step = step; it.ctl = ctl; it.freq = freq; it.ack = ack;
      it.chk_ir = chk_ir; it.ir = ir; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic cmp(input string tag, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // Monitor: compares each cycle's outputs mid-cycle against the scoreboard
   always @(negedge clk) begin
      if (q.size() > 0) begin
         item_t it;
         it = q.pop_front();
         cmp((it.tag != "") ? it.tag : "R3", "step", int'(step_o), it.step);
         cmp((it.tag != "") ? it.tag : "R5", "ctl", int'(ctl_o), it.ctl);
         cmp((it.tag != "") ? it.tag : "R4/R6", "fetch_req", int'(fetch_req_o), it.freq);
         cmp((it.tag != "") ? it.tag : "R7", "irq_ack", int'(irq_ack_o), it.ack);
         if (it.chk_ir) cmp((it.tag != "") ? it.tag : "R2", "ir", int'(ir_o), it.ir);
      end
   end

   // Driver: called just after a rising edge that starts a fetch cycle
   task automatic do_instr(input logic [7:0] op, input bit irq_last, input bit irq_mid, input bit first);
      logic [7:0] act;
      int n;
      bus_din = op;
      irq_req = irq_mid;
      push_item(0, pend ? 'h00 : 'h03, 0, pend ? 1 : 0, 1'b0, 0, first ? "R1" : "");
      act  = pend ? 8'h00 : op;
      pend = 1'b0;
      n    = exp_len(act);
      @(posedge clk); #1;
      for (int s = 1; s < n; s++) begin
         bus_din = op ^ 8'hFF ^ 8'(s);
         irq_req = (s == n - 1) ? irq_last : irq_mid;
         push_item(s, exp_ctl(act, s), (s == n - 1) ? 1 : 0, 0, 1'b1, int'(act),
                   known(act) ? "" : "R8");
         if (s == n - 1 && irq_last) pend = 1'b1;
         @(posedge clk); #1;
      end
      irq_req = 1'b0;
   endtask

   initial begin
      #800000;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      // R1: first cycle after reset is a plain fetch
      do_instr(8'hA9, 1'b0, 1'b0, 1'b1);
      // R7: irq only in non-final cycles is ignored
      do_instr(8'h6D, 1'b0, 1'b1, 1'b0);
      do_instr(8'hA9, 1'b0, 1'b0, 1'b0);
      // R7: irq in the final cycle of a store forces interrupt entry next
      do_instr(8'h8D, 1'b1, 1'b0, 1'b0);
      do_instr(8'hA9, 1'b0, 1'b0, 1'b0);
      // R8: opcodes without entry
      do_instr(8'h33, 1'b0, 1'b0, 1'b0);
      do_instr(8'hEA, 1'b0, 1'b0, 1'b0);
      // R4: interrupt-entry opcode fetched from the bus
      do_instr(8'h00, 1'b0, 1'b0, 1'b0);
      // R7: irq at the end of a 2-cycle instruction
      do_instr(8'hA9, 1'b1, 1'b0, 1'b0);
      do_instr(8'h6D, 1'b0, 1'b0, 1'b0);
      // R1: reset during a pending interrupt's fetch cancels it
      do_instr(8'hA9, 1'b1, 1'b0, 1'b0);
      bus_din = 8'h8D;
      rst = 1'b1;
      push_item(0, 'h00, 0, 1, 1'b0, 0, "R7");
      @(posedge clk); #1;
      rst  = 1'b0;
      pend = 1'b0;
      do_instr(8'h6D, 1'b0, 1'b0, 1'b1);
      // R1: reset in the middle of a store
      bus_din = 8'h8D;
      push_item(0, 'h03, 0, 0, 1'b0, 0, "");
      @(posedge clk); #1;
      bus_din = 8'h11;
      push_item(1, 'h06, 0, 0, 1'b1, 'h8D, "");
      @(posedge clk); #1;
      rst = 1'b1;
      push_item(2, 'h06, 0, 0, 1'b1, 'h8D, "");
      @(posedge clk); #1;
      rst = 1'b0;
      do_instr(8'h8D, 1'b0, 1'b1, 1'b1);
      for (int k = 0; k < 8; k++) begin
         do_instr(8'(k * 37 + 5), 1'b0, 1'b0, 1'b0);
      end
      do_instr(8'hA9, 1'b0, 1'b0, 1'b0);
      repeat (2) @(negedge clk);
      if (q.size() != 0) begin
         n_cmp++;
         n_bad++;
         $display("FAIL R3 scoreboard: actual %0d left expected 0", q.size());
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule